// File: doc/BRIEF.md
# Level Interrupt Cause Aggregator

This block gathers seven interrupt sources into a pending register and an enable register, and drives one combined request line toward a parent interrupt controller. Each source sets its pending bit for every cycle it is asserted. The bit then stays set until software changes it. Software reads the pending register, services the sources it finds there, and writes the register back with the serviced bits cleared.

The pending register is plain read-write: a written 1 sets a bit and a written 0 clears it. A source asserted in the same cycle as a software write therefore keeps its bit set, whatever value is written to that bit. This keeps an event from being lost in the read-modify-write window.

The block also reports the number of the highest-numbered source that is both pending and enabled, because service order runs from high to low. It counts read strobes that find nothing pending and enabled, as spurious reads, in a counter that saturates.

Top module: `irq_cause_agg`

## Requirements
- R1: After a synchronous active-low reset, the pending register, the enable register and the spurious counter are all zero, and `irq_req` and `top_valid` are low.
- R2: A source asserted in a cycle sets its pending bit at the next clock edge. With no source asserted and no write, the bit keeps its value.
- R3: A pending write loads `wr_data` into the pending register at the next edge: a 1 sets a bit and a 0 clears it.
- R4: When a source is asserted in the same cycle as a pending write of 0 to its bit, the bit is set after the edge.
- R5: An enable write loads `wr_data` into the enable register at the next edge. Bit n at 1 enables source n and at 0 masks it. The enable register never alters the pending register.
- R6: `irq_req` is high exactly when some bit is set in both the pending and the enable registers.
- R7: `top_valid` is high when any source is pending and enabled. `top_idx` is then the highest such source number, from 0 to 6; with none, `top_idx` is 0.
- R8: A read strobe in a cycle with no source pending and enabled adds one to `spur_cnt` at the next edge. A read strobe with a source pending and enabled leaves it unchanged.
- R9: `spur_cnt` saturates at 255 and stays there under further spurious reads.
- R10: A pending write and an enable write in the same cycle both load `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_evt | input | 7 | Source request lines, one per source |
| wr_cause | input | 1 | Write strobe for the pending register |
| wr_mask | input | 1 | Write strobe for the enable register |
| wr_data | input | 7 | Write data shared by both registers |
| rd_strobe | input | 1 | Software read of the pending register |
| cause_q | output | 7 | Pending register |
| mask_q | output | 7 | Enable register |
| irq_req | output | 1 | Combined request to the parent controller |
| top_valid | output | 1 | A pending enabled source exists |
| top_idx | output | 3 | Highest pending enabled source number |
| spur_cnt | output | 8 | Saturating count of spurious reads |

## Verification
The bench drives a source in the same cycle as a write of 0 to its bit; a design that let the write win would lose the event and show the bit clear. It also clears one bit while setting another in the same cycle, which exposes a merge that applies the source or the write data to the wrong bits. Masking a higher pending bit checks that `top_idx` follows only enabled sources; an encoder that ignored the mask would report 5 instead of 4. More than 255 spurious reads in a row check saturation: a counter that wrapped would read a small value. Read strobes with a source pending must leave the counter unchanged.

// File: rtl/irqagg_pkg.sv
// Package: shared defaults for the interrupt cause aggregator.
// Assumes: the sizes here feed parameter defaults only.
package irqagg_pkg;
    localparam int unsigned DEF_NUM_SRC = 7;
    localparam int unsigned DEF_CNT_W   = 8;

    // Index width for a given source count (at least one bit).
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/irqagg_cause_reg.sv
// Module: pending register, one generated bit slice per source.
// Each bit is set by its source and loaded by a software write; a source
// wins over a written 0 in the same cycle.
// Assumes: src_evt is synchronous to clk.
module irqagg_cause_reg #(
    parameter int unsigned NUM_SRC = irqagg_pkg::DEF_NUM_SRC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_evt,
    input  logic               wr_en,
    input  logic [NUM_SRC-1:0] wr_data,
    output logic [NUM_SRC-1:0] cause_q
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        logic nxt;

        // Merge the write value and the event for this bit.
        always_comb begin
            nxt = wr_en ? wr_data[i] : cause_q[i];
            if (src_evt[i]) nxt = 1'b1;
        end

        // Hold the pending bit.
        always_ff @(posedge clk) begin
            if (!rst_n) cause_q[i] <= 1'b0;
            else        cause_q[i] <= nxt;
        end

        AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            src_evt[i] |=> cause_q[i]); // R2
        AST_EVT_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            (src_evt[i] && wr_en && !wr_data[i]) |=> cause_q[i]); // R4
        AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!src_evt[i] && !wr_en) |=> $stable(cause_q[i])); // R2
        AST_WR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            (!src_evt[i] && wr_en && !wr_data[i]) |=> !cause_q[i]); // R3
        AST_WR_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_data[i]) |=> cause_q[i]); // R3
    end
endmodule

// File: rtl/irqagg_mask_reg.sv
// Module: enable register, loaded whole by a software write.
// Assumes: a 1 enables a source; the reset value masks all of them.
module irqagg_mask_reg #(
    parameter int unsigned NUM_SRC = irqagg_pkg::DEF_NUM_SRC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [NUM_SRC-1:0] wr_data,
    output logic [NUM_SRC-1:0] mask_q
);
    // Load the enable bits on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)     mask_q <= '0;
        else if (wr_en) mask_q <= wr_data;
    end

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mask_q == $past(wr_data))); // R5
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask_q)); // R5
endmodule

// File: rtl/irqagg_prio_enc.sv
// Module: finds the highest-numbered set bit of the pending-and-enabled vector.
// Assumes: purely combinational; gives index 0 and valid low when none is set.
module irqagg_prio_enc #(
    parameter int unsigned NUM_SRC = irqagg_pkg::DEF_NUM_SRC,
    localparam int unsigned IDX_W  = irqagg_pkg::idx_width(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] pend,
    output logic               valid,
    output logic [IDX_W-1:0]   idx
);
    // Scan upward so the highest set bit is the last one recorded.
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend[i]) begin
                valid = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irqagg_spur_cnt.sv
// Module: saturating counter of read strobes that find nothing to service.
// Assumes: pend_any reflects the registered state in the strobe cycle.
module irqagg_spur_cnt #(
    parameter int unsigned CNT_W = irqagg_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_strobe,
    input  logic             pend_any,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count spurious reads, stopping at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (rd_strobe && !pend_any && (cnt != CNT_MAX))
            cnt <= cnt + 1'b1;
    end

    AST_SPUR_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !pend_any && cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1)); // R8
    AST_REAL_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && pend_any) |=> $stable(cnt)); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX) |=> (cnt == CNT_MAX)); // R9
endmodule

// File: rtl/irq_cause_agg.sv
// Module: top of the level interrupt cause aggregator. Combines the pending
// and enable registers into one request, reports the highest pending
// enabled source and counts spurious reads.
// Assumes: all inputs synchronous to clk; reset is synchronous, active low.
module irq_cause_agg #(
    parameter int unsigned NUM_SRC = irqagg_pkg::DEF_NUM_SRC,
    parameter int unsigned CNT_W   = irqagg_pkg::DEF_CNT_W,
    localparam int unsigned IDX_W  = irqagg_pkg::idx_width(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_evt,
    input  logic               wr_cause,
    input  logic               wr_mask,
    input  logic [NUM_SRC-1:0] wr_data,
    input  logic               rd_strobe,
    output logic [NUM_SRC-1:0] cause_q,
    output logic [NUM_SRC-1:0] mask_q,
    output logic               irq_req,
    output logic               top_valid,
    output logic [IDX_W-1:0]   top_idx,
    output logic [CNT_W-1:0]   spur_cnt
);
    logic [NUM_SRC-1:0] pend;

    irqagg_cause_reg #(.NUM_SRC(NUM_SRC)) u_cause (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt),
        .wr_en(wr_cause), .wr_data(wr_data), .cause_q(cause_q)
    );

    irqagg_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_mask),
        .wr_data(wr_data), .mask_q(mask_q)
    );

    // Pending-and-enabled sources and the combined request.
    always_comb begin
        pend    = cause_q & mask_q;
        irq_req = |pend;
    end

    irqagg_prio_enc #(.NUM_SRC(NUM_SRC)) u_enc (
        .pend(pend), .valid(top_valid), .idx(top_idx)
    );

    irqagg_spur_cnt #(.CNT_W(CNT_W)) u_spur (
        .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe),
        .pend_any(irq_req), .cnt(spur_cnt)
    );

    AST_REQ_MATCHES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req == top_valid); // R6
    AST_TOP_IS_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
        top_valid |-> ((pend >> top_idx) == NUM_SRC'(1))); // R7
    AST_IDLE_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !top_valid |-> (top_idx == '0)); // R7
    AST_MASK_KEEPS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mask && !wr_cause && src_evt == '0) |=> $stable(cause_q)); // R5
endmodule

// File: tb/sim_irq_cause_agg.sv
module sim_irq_cause_agg;
    localparam time CLK_PER = 10ns;
    localparam int  NV = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] src_evt = '0;
    logic       wr_cause = 1'b0;
    logic       wr_mask = 1'b0;
    logic [6:0] wr_data = '0;
    logic       rd_strobe = 1'b0;
    logic [6:0] cause_q, mask_q;
    logic       irq_req, top_valid;
    logic [2:0] top_idx;
    logic [7:0] spur_cnt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    irq_cause_agg u0 (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .wr_cause(wr_cause),
        .wr_mask(wr_mask), .wr_data(wr_data), .rd_strobe(rd_strobe),
        .cause_q(cause_q), .mask_q(mask_q), .irq_req(irq_req),
        .top_valid(top_valid), .top_idx(top_idx), .spur_cnt(spur_cnt)
    );

    // Row: src, wc, wm, wdata | exp cause, exp mask, exp irq, exp valid, exp idx
    localparam logic [34:0] TBL [0:NV-1] = '{
        {7'h00,1'b0,1'b1,7'h7F, 7'h00,7'h7F,1'b0,1'b0,3'd0}, // R5 enable all
        {7'h05,1'b0,1'b0,7'h00, 7'h05,7'h7F,1'b1,1'b1,3'd2}, // R2 R7 sources 0,2
        {7'h00,1'b0,1'b0,7'h00, 7'h05,7'h7F,1'b1,1'b1,3'd2}, // R2 sticky
        {7'h00,1'b1,1'b0,7'h01, 7'h01,7'h7F,1'b1,1'b1,3'd0}, // R3 clear bit 2
        {7'h00,1'b1,1'b0,7'h40, 7'h40,7'h7F,1'b1,1'b1,3'd6}, // R3 write 1 sets
        {7'h40,1'b1,1'b0,7'h00, 7'h40,7'h7F,1'b1,1'b1,3'd6}, // R4 event wins
        {7'h08,1'b1,1'b0,7'h00, 7'h08,7'h7F,1'b1,1'b1,3'd3}, // R4 clear 6, set 3
        {7'h00,1'b0,1'b1,7'h10, 7'h08,7'h10,1'b0,1'b0,3'd0}, // R5 R6 masked
        {7'h30,1'b0,1'b0,7'h00, 7'h38,7'h10,1'b1,1'b1,3'd4}, // R7 bit5 masked
        {7'h00,1'b0,1'b1,7'h7F, 7'h38,7'h7F,1'b1,1'b1,3'd5}, // R7 unmask 5
        {7'h00,1'b1,1'b0,7'h00, 7'h00,7'h7F,1'b0,1'b0,3'd0}, // R3 R6 clear all
        {7'h00,1'b1,1'b1,7'h22, 7'h22,7'h22,1'b1,1'b1,3'd5}  // R10 both writes
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drive one cycle of stimulus after a falling edge, return after the rising edge.
    task automatic cyc(input logic [6:0] s, input logic wc, input logic wm,
                       input logic [6:0] wd, input logic rd);
        @(negedge clk);
        src_evt = s; wr_cause = wc; wr_mask = wm; wr_data = wd; rd_strobe = rd;
        @(posedge clk);
        #1;
        src_evt = '0; wr_cause = 1'b0; wr_mask = 1'b0; wr_data = '0; rd_strobe = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PER * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", "cause", 32'(cause_q), 0);
        chk("R1", "mask", 32'(mask_q), 0);
        chk("R1", "irq", 32'(irq_req), 0);
        chk("R1", "valid", 32'(top_valid), 0);
        chk("R1", "spur", 32'(spur_cnt), 0);

        // Vector table walk (R2 R3 R4 R5 R6 R7 R10)
        for (int v = 0; v < NV; v++) begin
            cyc(TBL[v][34:28], TBL[v][27], TBL[v][26], TBL[v][25:19], 1'b0);
            chk($sformatf("R2-7/R10 vec%0d", v), "cause", 32'(cause_q), 32'(TBL[v][18:12]));
            chk($sformatf("R5 vec%0d", v), "mask", 32'(mask_q), 32'(TBL[v][11:5]));
            chk($sformatf("R6 vec%0d", v), "irq", 32'(irq_req), 32'(TBL[v][4]));
            chk($sformatf("R7 vec%0d", v), "valid", 32'(top_valid), 32'(TBL[v][3]));
            chk($sformatf("R7 vec%0d", v), "idx", 32'(top_idx), 32'(TBL[v][2:0]));
        end

        // R8: read with pending enabled source does not count
        cyc(7'h00, 1'b0, 1'b0, 7'h00, 1'b1);
        chk("R8", "spur real read", 32'(spur_cnt), 0);
        // R8: mask everything, the read is spurious
        cyc(7'h00, 1'b0, 1'b1, 7'h00, 1'b0);
        cyc(7'h00, 1'b0, 1'b0, 7'h00, 1'b1);
        chk("R8", "spur masked read", 32'(spur_cnt), 1);
        chk("R5", "cause kept under mask", 32'(cause_q), 32'h22);

        // R1: mid-run reset clears everything
        do_reset();
        chk("R1", "cause after reset", 32'(cause_q), 0);
        chk("R1", "mask after reset", 32'(mask_q), 0);
        chk("R1", "spur after reset", 32'(spur_cnt), 0);

        // R9: 260 spurious reads saturate at 255
        @(negedge clk);
        rd_strobe = 1'b1;
        for (int k = 0; k < 254; k++) @(posedge clk);
        #1;
        chk("R9", "spur at 254", 32'(spur_cnt), 254);
        for (int k = 0; k < 6; k++) @(posedge clk);
        #1;
        rd_strobe = 1'b0;
        chk("R9", "spur saturated", 32'(spur_cnt), 255);

        // R4 on bit 0 with the enable also loaded (R10)
        cyc(7'h01, 1'b1, 1'b1, 7'h00, 1'b0);
        chk("R4", "bit0 event beats clear", 32'(cause_q), 32'h01);
        chk("R10", "mask loaded with same data", 32'(mask_q), 0);
        chk("R6", "irq masked", 32'(irq_req), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule